// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This unit holds eight lock flags shared by two independent ports, left and right, that sit beside a shared memory. Software on either side claims a flag by writing 0 to it and gives it back by writing 1. The flag then reports whether that side owns it. Each flag is a token that at most one side holds at a time. A claim made while the other side holds the flag is kept pending. The pending claim is granted as soon as the holder gives the flag back.

Each port has its own decode. Two memory enables (one active-low, one active-high) form a chip enable. A semaphore select picks the flag space. The port also has a read/write strobe, an output enable, a 3-bit flag address and an 8-bit data bus split into in, out and output-enable. Everything runs on one system clock. A write is recognised at the rising edge of the port's strobe, which a registered detector finds, and it changes the flag one clock later.

Top module: `sema_unit`

## Requirements
- R1: After reset every flag is free, and a semaphore read from either port returns 8'hFF.
- R2: Writing 0 to a free flag grants it to the writing port. That port then reads 8'h00 at that address, and the other port reads 8'hFF.
- R3: A semaphore write uses only data bit 0. Bits 7..1 of the written value have no effect.
- R4: During a semaphore read the selected flag's state is driven on all eight data outputs: 8'h00 when the reading port owns the flag, otherwise 8'hFF. The output-enable is asserted.
- R5: The data output-enable is 1 only when the semaphore select is low, the chip enable is inactive, the strobe is high and the output enable is low. In every other case it is 0.
- R6: The chip enable is active only when the active-low enable is 0 and the active-high enable is 1. With the chip enable active and the semaphore select low, a strobe edge changes no flag. With any other enable pair, the semaphore access works normally.
- R7: Writing 0 to a flag that the other port owns leaves ownership unchanged. The requester keeps reading 8'hFF and its request stays pending.
- R8: When the owner writes 1, ownership passes at once to the other port if that port has a request pending. The new owner reads 8'h00 and the old owner reads 8'hFF.
- R9: If both ports write 0 to the same free flag in the same cycle, the left port becomes owner and the right request stays pending.
- R10: Suppose the strobe is first sampled high at clock edge E1 after being low. The flag's new value is then visible after the next edge E2, and not before it.
- R11: The three address bits pick one of eight independent flags. A write to one flag leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lCeN | input | 1 | Left active-low memory enable |
| lCe | input | 1 | Left active-high memory enable |
| lSemN | input | 1 | Left semaphore select, active low |
| lRw | input | 1 | Left read/write strobe (1 read, rising edge writes) |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | 3 | Left flag address |
| lDin | input | 8 | Left data in |
| lDout | output | 8 | Left data out |
| lDoe | output | 1 | Left data output-enable |
| rCeN | input | 1 | Right active-low memory enable |
| rCe | input | 1 | Right active-high memory enable |
| rSemN | input | 1 | Right semaphore select, active low |
| rRw | input | 1 | Right read/write strobe |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | 3 | Right flag address |
| rDin | input | 8 | Right data in |
| rDout | output | 8 | Right data out |
| rDoe | output | 1 | Right data output-enable |

## Verification
Two things can land on the same flag in one cycle: a claim from both ports, or a release by one port while the other has a claim pending. The bench starts both strobes in the same cycle with 0 on the same free flag. It expects left ownership and a pending right claim. It then releases from the left and expects the right side to read 0 at once, which shows the pending claim was handed over and not lost. A checker also watches that the two ports never both read 0 from the same address.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int unsigned NUM_FLAGS = 8;
  localparam int unsigned ADDR_W    = $clog2(NUM_FLAGS);

  typedef struct packed {
    logic              wrEn;
    logic              wrBit;
    logic [ADDR_W-1:0] wrAddr;
  } portStrobe_t;

  typedef struct packed {
    portStrobe_t left;
    portStrobe_t right;
  } ctrlStrobes_t;
endpackage

// File: rtl/sema_port.sv
module sema_port
  import sema_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              ce,
  input  logic              semN,
  input  logic              rw,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output portStrobe_t       strobe,
  output logic              rdEn
);
  logic chipOn;
  logic semSel;
  logic rwPrev;
  logic rwRise;
  logic unusedDin;

  assign chipOn    = ~ceN & ce;
  assign semSel    = ~chipOn & ~semN;
  assign rwRise    = rw & ~rwPrev;
  assign rdEn      = semSel & rw & ~oeN;
  assign unusedDin = ^din[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rwPrev <= 1'b1;
      strobe <= '0;
    end else begin
      rwPrev        <= rw;
      strobe.wrEn   <= rwRise & semSel;
      strobe.wrBit  <= din[0];
      strobe.wrAddr <= addr;
    end
  end
endmodule

// File: rtl/sema_core.sv
module sema_core
  import sema_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic              lRdEn,
  input  logic [ADDR_W-1:0] lRdAddr,
  input  logic              rRdEn,
  input  logic [ADDR_W-1:0] rRdAddr,
  output logic [DATA_W-1:0] lDout,
  output logic              lDoe,
  output logic [DATA_W-1:0] rDout,
  output logic              rDoe
);
  logic [NUM_FLAGS-1:0] ownL;
  logic [NUM_FLAGS-1:0] ownR;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    logic reqLQ, reqRQ, ownLQ, ownRQ;
    logic hitL, hitR, rqL, rqR, keepL, keepR, nxtL, nxtR;

    always_comb begin
      hitL  = stb.left.wrEn  && (stb.left.wrAddr  == ADDR_W'(i));
      hitR  = stb.right.wrEn && (stb.right.wrAddr == ADDR_W'(i));
      rqL   = hitL ? ~stb.left.wrBit  : reqLQ;
      rqR   = hitR ? ~stb.right.wrBit : reqRQ;
      keepL = ownLQ & rqL;
      keepR = ownRQ & rqR;
      if (keepL || keepR) begin
        nxtL = keepL;
        nxtR = keepR;
      end else begin
        nxtL = rqL;
        nxtR = rqR & ~rqL;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqLQ <= 1'b0;
        reqRQ <= 1'b0;
        ownLQ <= 1'b0;
        ownRQ <= 1'b0;
      end else begin
        reqLQ <= rqL;
        reqRQ <= rqR;
        ownLQ <= nxtL;
        ownRQ <= nxtR;
      end
    end

    assign ownL[i] = ownLQ;
    assign ownR[i] = ownRQ;
  end

  assign lDout = {DATA_W{~ownL[lRdAddr]}};
  assign rDout = {DATA_W{~ownR[rRdAddr]}};
  assign lDoe  = lRdEn;
  assign rDoe  = rRdEn;
endmodule

// File: rtl/sema_unit.sv
module sema_unit
  import sema_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lCe,
  input  logic              lSemN,
  input  logic              lRw,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lDin,
  output logic [DATA_W-1:0] lDout,
  output logic              lDoe,
  input  logic              rCeN,
  input  logic              rCe,
  input  logic              rSemN,
  input  logic              rRw,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rDin,
  output logic [DATA_W-1:0] rDout,
  output logic              rDoe
);
  ctrlStrobes_t stb;
  logic lRdEn, rRdEn;

  sema_port #(.DATA_W(DATA_W)) uLeft (
    .clk(clk), .rstN(rstN), .ceN(lCeN), .ce(lCe), .semN(lSemN), .rw(lRw),
    .oeN(lOeN), .addr(lAddr), .din(lDin), .strobe(stb.left), .rdEn(lRdEn)
  );

  sema_port #(.DATA_W(DATA_W)) uRight (
    .clk(clk), .rstN(rstN), .ceN(rCeN), .ce(rCe), .semN(rSemN), .rw(rRw),
    .oeN(rOeN), .addr(rAddr), .din(rDin), .strobe(stb.right), .rdEn(rRdEn)
  );

  sema_core #(.DATA_W(DATA_W)) uCore (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lRdEn(lRdEn), .lRdAddr(lAddr), .rRdEn(rRdEn), .rRdAddr(rAddr),
    .lDout(lDout), .lDoe(lDoe), .rDout(rDout), .rDoe(rDoe)
  );
endmodule

// File: rtl/sema_unit_chk.sv
module sema_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              lCeN,
  input logic              lCe,
  input logic              lSemN,
  input logic              lRw,
  input logic              lOeN,
  input logic [ADDR_W-1:0] lAddr,
  input logic [DATA_W-1:0] lDout,
  input logic              lDoe,
  input logic [ADDR_W-1:0] rAddr,
  input logic [DATA_W-1:0] rDout,
  input logic              rDoe
);
  a_r4_left_replicated: assert property (@(posedge clk) disable iff (!rstN)
    lDoe |-> (lDout == '0 || lDout == '1));

  a_r4_right_replicated: assert property (@(posedge clk) disable iff (!rstN)
    rDoe |-> (rDout == '0 || rDout == '1));

  a_r5_left_gating: assert property (@(posedge clk) disable iff (!rstN)
    lDoe |-> (!lSemN && lRw && !lOeN && !(!lCeN && lCe)));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (lDoe && rDoe && lAddr == rAddr) |-> !(lDout == '0 && rDout == '0));

  a_r1_free_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (lDoe && !$past(rstN)) |-> (lDout == '1));
endmodule

bind sema_unit sema_unit_chk #(.DATA_W(DATA_W), .ADDR_W(sema_pkg::ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .lCeN(lCeN), .lCe(lCe), .lSemN(lSemN), .lRw(lRw),
  .lOeN(lOeN), .lAddr(lAddr), .lDout(lDout), .lDoe(lDoe),
  .rAddr(rAddr), .rDout(rDout), .rDoe(rDoe)
);

// File: tb/sema_unit_test.sv
`timescale 1ns/1ps
module sema_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCeN, lCe, lSemN, lRw, lOeN;
  logic [2:0] lAddr;
  logic [7:0] lDin, lDout;
  logic lDoe;
  logic rCeN, rCe, rSemN, rRw, rOeN;
  logic [2:0] rAddr;
  logic [7:0] rDin, rDout;
  logic rDoe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sema_unit uut (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lCe(lCe), .lSemN(lSemN), .lRw(lRw), .lOeN(lOeN),
    .lAddr(lAddr), .lDin(lDin), .lDout(lDout), .lDoe(lDoe),
    .rCeN(rCeN), .rCe(rCe), .rSemN(rSemN), .rRw(rRw), .rOeN(rOeN),
    .rAddr(rAddr), .rDin(rDin), .rDout(rDout), .rDoe(rDoe)
  );

  // vector: {tag[3:0], right, write, addr[2:0], data[7:0], expect[7:0]}
  localparam int NV = 19;
  localparam logic [24:0] VECS [NV] = '{
    {4'd1,  1'b0, 1'b0, 3'd0, 8'h00, 8'hFF},  // R1 left free
    {4'd1,  1'b1, 1'b0, 3'd0, 8'h00, 8'hFF},  // R1 right free
    {4'd3,  1'b0, 1'b1, 3'd0, 8'hFE, 8'h00},  // R3 claim, upper bits set
    {4'd2,  1'b0, 1'b0, 3'd0, 8'h00, 8'h00},  // R2 owner reads 0
    {4'd2,  1'b1, 1'b0, 3'd0, 8'h00, 8'hFF},  // R2 other reads 1
    {4'd7,  1'b1, 1'b1, 3'd0, 8'h00, 8'h00},  // R7 right claims while held
    {4'd7,  1'b1, 1'b0, 3'd0, 8'h00, 8'hFF},  // R7 pending reads 1
    {4'd7,  1'b0, 1'b0, 3'd0, 8'h00, 8'h00},  // R7 left still owner
    {4'd8,  1'b0, 1'b1, 3'd0, 8'h01, 8'h00},  // R8 left releases
    {4'd8,  1'b1, 1'b0, 3'd0, 8'h00, 8'h00},  // R8 right now owner
    {4'd8,  1'b0, 1'b0, 3'd0, 8'h00, 8'hFF},  // R8 left reads 1
    {4'd11, 1'b0, 1'b0, 3'd1, 8'h00, 8'hFF},  // R11 other flag untouched
    {4'd3,  1'b1, 1'b1, 3'd0, 8'h81, 8'h00},  // R3 release via bit 0
    {4'd3,  1'b1, 1'b0, 3'd0, 8'h00, 8'hFF},  // R3 released
    {4'd11, 1'b0, 1'b1, 3'd7, 8'hF0, 8'h00},  // R11 claim flag 7
    {4'd11, 1'b0, 1'b0, 3'd7, 8'h00, 8'h00},  // R11 flag 7 owned
    {4'd11, 1'b1, 1'b0, 3'd6, 8'h00, 8'hFF},  // R11 flag 6 free
    {4'd11, 1'b0, 1'b1, 3'd7, 8'h0F, 8'h00},  // R11 release flag 7
    {4'd11, 1'b0, 1'b0, 3'd7, 8'h00, 8'hFF}   // R11 flag 7 free
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setPort(input bit right, input logic ceN, input logic ce,
                         input logic semN, input logic rw, input logic oeN,
                         input logic [2:0] addr, input logic [7:0] din);
    if (right) begin
      rCeN = ceN; rCe = ce; rSemN = semN; rRw = rw; rOeN = oeN; rAddr = addr; rDin = din;
    end else begin
      lCeN = ceN; lCe = ce; lSemN = semN; lRw = rw; lOeN = oeN; lAddr = addr; lDin = din;
    end
  endtask

  task automatic idleAll();
    setPort(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
    setPort(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
  endtask

  task automatic writeOp(input bit useL, input bit useR, input logic [2:0] addr,
                         input logic [7:0] din, input logic ceN, input logic ce);
    @(negedge clk);
    if (useL) setPort(1'b0, ceN, ce, 1'b0, 1'b0, 1'b1, addr, din);
    if (useR) setPort(1'b1, ceN, ce, 1'b0, 1'b0, 1'b1, addr, din);
    @(negedge clk);
    if (useL) lRw = 1'b1;
    if (useR) rRw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    idleAll();
  endtask

  task automatic readChk(input bit right, input logic [2:0] addr,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    setPort(right, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, addr, 8'h00);
    #1;
    chk(tag, right ? rDout : lDout, exp);
    chk({tag, " oe"}, {7'd0, right ? rDoe : lDoe}, 8'h01);
    idleAll();
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idleAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state, R1
    readChk(1'b0, 3'd5, 8'hFF, "R1 reset left");
    readChk(1'b1, 3'd5, 8'hFF, "R1 reset right");

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[i][24:21], i);
      if (VECS[i][19])
        writeOp(!VECS[i][20], VECS[i][20], VECS[i][18:16], VECS[i][15:8], 1'b1, 1'b0);
      else
        readChk(VECS[i][20], VECS[i][18:16], VECS[i][7:0], tag);
    end

    // R5: output-enable gating
    @(negedge clk);
    setPort(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00); #1;
    chk("R5 oeN high", {7'd0, lDoe}, 8'h00);
    setPort(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00); #1;
    chk("R5 chip active", {7'd0, lDoe}, 8'h00);
    setPort(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 8'h00); #1;
    chk("R5 sem deselected", {7'd0, lDoe}, 8'h00);
    setPort(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00); #1;
    chk("R5 strobe low", {7'd0, lDoe}, 8'h00);
    idleAll();

    // R6: illegal combination starts nothing; other enable pairs work
    writeOp(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b1);
    readChk(1'b0, 3'd2, 8'hFF, "R6 illegal write ignored");
    writeOp(1'b1, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0);
    readChk(1'b0, 3'd3, 8'h00, "R6 enable pair 00 deselects chip");
    writeOp(1'b1, 1'b0, 3'd3, 8'h01, 1'b1, 1'b1);
    readChk(1'b0, 3'd3, 8'hFF, "R6 enable pair 11 deselects chip");

    // R9: simultaneous claim, left wins, right pending
    writeOp(1'b1, 1'b1, 3'd4, 8'h00, 1'b1, 1'b0);
    readChk(1'b0, 3'd4, 8'h00, "R9 left wins");
    readChk(1'b1, 3'd4, 8'hFF, "R9 right loses");
    writeOp(1'b1, 1'b0, 3'd4, 8'h01, 1'b1, 1'b0);
    readChk(1'b1, 3'd4, 8'h00, "R9 right pending granted");
    writeOp(1'b0, 1'b1, 3'd4, 8'h01, 1'b1, 1'b0);
    readChk(1'b1, 3'd4, 8'hFF, "R9 right released");

    // R10: latency from strobe edge
    @(negedge clk);
    setPort(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 8'h00);
    @(negedge clk);
    lRw = 1'b1; lOeN = 1'b0;
    @(negedge clk);
    chk("R10 after E1", lDout, 8'hFF);
    @(negedge clk);
    chk("R10 after E2", lDout, 8'h00);
    idleAll();
    writeOp(1'b1, 1'b0, 3'd5, 8'h01, 1'b1, 1'b0);
    readChk(1'b0, 3'd5, 8'hFF, "R10 released");

    finishRun();
  end
endmodule